// File: doc/BRIEF.md
# Vector Register Strobe Synchronizer

This block is a memory-mapped register bank, reached over an AXI4-Lite slave port, that sits between a processor and a piece of user logic. It moves multi-word vectors across the bus without tearing. A bus master can only touch one 32-bit word per transaction, so a six-word vector moves across the bus over many cycles. Meanwhile the user logic keeps running. To keep the vector coherent, each vector direction has its own strobe register.

On the input side, software fills six staging words one at a time. A single strobe write then copies all six into shadow registers, and those shadow registers are the only thing the user logic sees. On the output side, a strobe write freezes all six words of the core's result vector in one cycle. The following sequential reads return that frozen snapshot. For comparison, six plain scalar words are read live, so a running source gives a different value on each read. A one-bit control register enables the user logic.

Every write updates the full word; byte lanes cannot be selected. Both strobes act only when bit 0 of the written data is 1, and they always read back as 0.

Top module: `vss_vector_regs`

## Requirements
- R1: After reset, `core_en` is 0, `vin_data` is all zeros, and every register reads 0.
- R2: Offset 0x004 is the control word. Bit 0 of a write sets `core_en`, which changes only on such a write, and reading the word returns `core_en` in bit 0.
- R3: Offsets 0x180 + 4·k (k = 0..5) are the input staging words. They read back what was written, and writing them leaves `vin_data` unchanged.
- R4: A write with bit 0 = 1 to offset 0x1A0 copies all six staging words into `vin_data` (word k in bits 32k+31..32k) at the accepting clock edge. A write with bit 0 = 0 has no effect.
- R5: A write with bit 0 = 1 to offset 0x160 captures all six words of `vout_src` at the accepting edge. A read of 0x140 + 4·k then returns word k of that capture.
- R6: Captured words keep their value until the next capture, however much `vout_src` changes in between.
- R7: Offsets 0x10C + 4·k return word k of `scal_src` as it stands at the read-accepting edge, with no capture.
- R8: Both strobe offsets, 0x160 and 0x1A0, always read as 0.
- R9: Writes to unmapped offsets change nothing, reads of them return 0, and every response code is OKAY (00).
- R10: Only one write and one read are outstanding at a time. The write response is asserted in the cycle after acceptance and held until taken. Read data is valid in the cycle after acceptance and held stable until taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awaddr | input | 12 | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response code |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | 12 | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response code |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| core_en | output | 1 | Enable to the user logic |
| vin_data | output | 192 | Shadowed input vector to the user logic |
| vout_src | input | 192 | Result vector from the user logic |
| scal_src | input | 192 | Six live scalar words from the user logic |

## Verification
A write takes effect at the clock edge that accepts it. `core_en`, `vin_data` and the capture registers therefore change at that edge, and the response appears one cycle later. A read samples its source at the accepting edge, and its data is valid one cycle later.

The bench drives every request half a cycle before the accepting edge. At that same moment it records the value of its free-running counter, which is exactly what the design samples. Expected data for live and captured words is derived from that recorded value and pushed into a queue. A monitor pops the queue at the falling edge on which read data is valid. Port-level checks on `core_en`, `vin_data` and `s_bvalid` are made at the falling edge after acceptance. The tasks leave one idle cycle between transactions, so a pending response never delays the next acceptance edge.

// File: rtl/vss_pkg.sv
package vss_pkg;
   localparam logic [1:0] RESP_OKAY = 2'b00;
   localparam int unsigned WORD_BYTES = 4;

   function automatic logic [31:0] word_off(input int unsigned base, input int unsigned k);
      return 32'(base + k * WORD_BYTES);
   endfunction
endpackage

// File: rtl/vss_axil_port.sv
module vss_axil_port #(
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] awaddr,
   input  logic              awvalid,
   output logic              awready,
   input  logic [DATA_W-1:0] wdata,
   input  logic              wvalid,
   output logic              wready,
   output logic [1:0]        bresp,
   output logic              bvalid,
   input  logic              bready,
   input  logic [ADDR_W-1:0] araddr,
   input  logic              arvalid,
   output logic              arready,
   output logic [DATA_W-1:0] rdata,
   output logic [1:0]        rresp,
   output logic              rvalid,
   input  logic              rready,
   output logic              wr_fire,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              rd_fire,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [DATA_W-1:0] rd_word
);
   import vss_pkg::*;

   logic bvalid_q, rvalid_q;
   logic [DATA_W-1:0] rdata_q;

   assign wr_fire = awvalid & wvalid & ~bvalid_q;
   assign awready = wr_fire;
   assign wready  = wr_fire;
   assign wr_addr = awaddr;
   assign wr_data = wdata;
   assign bvalid  = bvalid_q;
   assign bresp   = RESP_OKAY;

   assign rd_fire = arvalid & ~rvalid_q;
   assign arready = ~rvalid_q;
   assign rd_addr = araddr;
   assign rvalid  = rvalid_q;
   assign rdata   = rdata_q;
   assign rresp   = RESP_OKAY;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bvalid_q <= 1'b0;
      end else if (wr_fire) begin
         bvalid_q <= 1'b1;
      end else if (bready) begin
         bvalid_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rvalid_q <= 1'b0;
         rdata_q  <= '0;
      end else if (rd_fire) begin
         rvalid_q <= 1'b1;
         rdata_q  <= rd_word;
      end else if (rready) begin
         rvalid_q <= 1'b0;
      end
   end

   // R10: a response is held until the master takes it
   p_bvalid_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      bvalid && !bready |=> bvalid);
   p_rvalid_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rvalid && !rready |=> rvalid && $stable(rdata));
   p_no_accept_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
      bvalid |-> !awready);
endmodule

// File: rtl/vss_vec_in.sv
module vss_vec_in #(
   parameter int unsigned N_ELEM = 6,
   parameter int unsigned DATA_W = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [N_ELEM-1:0]        stg_we,
   input  logic [DATA_W-1:0]        wdata,
   input  logic                     load,
   output logic [N_ELEM*DATA_W-1:0] stg_flat,
   output logic [N_ELEM*DATA_W-1:0] shd_flat
);
   for (genvar k = 0; k < N_ELEM; k++) begin : g_elem
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            stg_flat[k*DATA_W +: DATA_W] <= '0;
         end else if (stg_we[k]) begin
            stg_flat[k*DATA_W +: DATA_W] <= wdata;
         end
      end
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            shd_flat[k*DATA_W +: DATA_W] <= '0;
         end else if (load) begin
            shd_flat[k*DATA_W +: DATA_W] <= stg_flat[k*DATA_W +: DATA_W];
         end
      end
   end

   // R3: staging traffic alone never reaches the core side
   p_shadow_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(shd_flat));
   // R4: after a load every element equals what was staged
   p_shadow_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> shd_flat == $past(stg_flat));
endmodule

// File: rtl/vss_vec_out.sv
module vss_vec_out #(
   parameter int unsigned N_ELEM = 6,
   parameter int unsigned DATA_W = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cap,
   input  logic [N_ELEM*DATA_W-1:0] src_flat,
   output logic [N_ELEM*DATA_W-1:0] cap_flat
);
   for (genvar k = 0; k < N_ELEM; k++) begin : g_elem
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cap_flat[k*DATA_W +: DATA_W] <= '0;
         end else if (cap) begin
            cap_flat[k*DATA_W +: DATA_W] <= src_flat[k*DATA_W +: DATA_W];
         end
      end
   end

   // R6: the snapshot holds between strobes
   p_cap_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !cap |=> $stable(cap_flat));
   // R5: all elements come from the same source cycle
   p_cap_coherent_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cap |=> cap_flat == $past(src_flat));
endmodule

// File: rtl/vss_vector_regs.sv
module vss_vector_regs #(
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned N_ELEM      = 6,
   parameter int unsigned OFF_CTRL    = 'h004,
   parameter int unsigned OFF_SCAL    = 'h10C,
   parameter int unsigned OFF_VOUT    = 'h140,
   parameter int unsigned OFF_VOUT_ST = 'h160,
   parameter int unsigned OFF_VIN     = 'h180,
   parameter int unsigned OFF_VIN_ST  = 'h1A0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ADDR_W-1:0]        s_awaddr,
   input  logic                     s_awvalid,
   output logic                     s_awready,
   input  logic [DATA_W-1:0]        s_wdata,
   input  logic                     s_wvalid,
   output logic                     s_wready,
   output logic [1:0]               s_bresp,
   output logic                     s_bvalid,
   input  logic                     s_bready,
   input  logic [ADDR_W-1:0]        s_araddr,
   input  logic                     s_arvalid,
   output logic                     s_arready,
   output logic [DATA_W-1:0]        s_rdata,
   output logic [1:0]               s_rresp,
   output logic                     s_rvalid,
   input  logic                     s_rready,
   output logic                     core_en,
   output logic [N_ELEM*DATA_W-1:0] vin_data,
   input  logic [N_ELEM*DATA_W-1:0] vout_src,
   input  logic [N_ELEM*DATA_W-1:0] scal_src
);
   import vss_pkg::*;

   localparam int unsigned SPAN     = N_ELEM * WORD_BYTES;
   localparam int unsigned ADDR_TOP = 1 << ADDR_W;

   if (DATA_W != 32) begin : g_bad_width
      $error("vss_vector_regs: DATA_W must be 32");
   end
   if (N_ELEM < 1) begin : g_bad_count
      $error("vss_vector_regs: N_ELEM must be at least 1");
   end
   if (OFF_SCAL + SPAN > OFF_VOUT || OFF_VOUT + SPAN > OFF_VOUT_ST ||
       OFF_VIN + SPAN > OFF_VIN_ST || OFF_CTRL >= OFF_SCAL) begin : g_bad_map
      $error("vss_vector_regs: register windows overlap");
   end
   if (OFF_VIN_ST >= ADDR_TOP || OFF_VOUT_ST >= ADDR_TOP) begin : g_bad_addr
      $error("vss_vector_regs: offsets exceed the address width");
   end

   logic              wr_fire, rd_fire;
   logic [ADDR_W-1:0] wr_addr, rd_addr;
   logic [DATA_W-1:0] wr_data, rd_word;
   logic [31:0]       wa, ra;
   logic              en_q, in_load, out_cap;
   logic [N_ELEM-1:0] stg_we;
   logic [N_ELEM*DATA_W-1:0] stg_flat, cap_flat;

   vss_axil_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
      .clk(clk), .rst_n(rst_n),
      .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
      .wdata(s_wdata), .wvalid(s_wvalid), .wready(s_wready),
      .bresp(s_bresp), .bvalid(s_bvalid), .bready(s_bready),
      .araddr(s_araddr), .arvalid(s_arvalid), .arready(s_arready),
      .rdata(s_rdata), .rresp(s_rresp), .rvalid(s_rvalid), .rready(s_rready),
      .wr_fire(wr_fire), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_fire(rd_fire), .rd_addr(rd_addr), .rd_word(rd_word)
   );

   assign wa = 32'(wr_addr);
   assign ra = 32'(rd_addr);

   assign in_load = wr_fire && wa == 32'(OFF_VIN_ST)  && wr_data[0];
   assign out_cap = wr_fire && wa == 32'(OFF_VOUT_ST) && wr_data[0];

   for (genvar k = 0; k < N_ELEM; k++) begin : g_stg_dec
      assign stg_we[k] = wr_fire && wa == word_off(OFF_VIN, k);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q <= 1'b0;
      end else if (wr_fire && wa == 32'(OFF_CTRL)) begin
         en_q <= wr_data[0];
      end
   end
   assign core_en = en_q;

   vss_vec_in #(.N_ELEM(N_ELEM), .DATA_W(DATA_W)) u_vin (
      .clk(clk), .rst_n(rst_n), .stg_we(stg_we), .wdata(wr_data),
      .load(in_load), .stg_flat(stg_flat), .shd_flat(vin_data)
   );

   vss_vec_out #(.N_ELEM(N_ELEM), .DATA_W(DATA_W)) u_vout (
      .clk(clk), .rst_n(rst_n), .cap(out_cap),
      .src_flat(vout_src), .cap_flat(cap_flat)
   );

   always_comb begin
      rd_word = '0;
      if (ra == 32'(OFF_CTRL)) begin
         rd_word[0] = en_q;
      end
      for (int k = 0; k < N_ELEM; k++) begin
         if (ra == word_off(OFF_SCAL, k)) rd_word = scal_src[k*DATA_W +: DATA_W];
         if (ra == word_off(OFF_VOUT, k)) rd_word = cap_flat[k*DATA_W +: DATA_W];
         if (ra == word_off(OFF_VIN, k))  rd_word = stg_flat[k*DATA_W +: DATA_W];
      end
   end

   // R2: the enable moves only on an accepted bus write
   p_en_write_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(core_en) |-> $past(wr_fire));
   // R4: the core-side vector moves only on an input strobe
   p_vin_strobe_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(vin_data) |-> $past(in_load));
   // R9: a read that misses every window returns zero
   p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_fire && ra >= 32'(OFF_VIN_ST) + 32'd4 |=> s_rdata == '0);
endmodule

// File: tb/sim_vss_vector_regs.sv
module sim_vss_vector_regs;
   localparam int CLK_PERIOD = 10;
   localparam int N = 6;
   localparam int W = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [11:0] awaddr = '0, araddr = '0;
   logic awvalid = 1'b0, wvalid = 1'b0, arvalid = 1'b0;
   logic bready = 1'b1, rready = 1'b1;
   logic [31:0] wdata = '0;
   logic awready, wready, bvalid, arready, rvalid, core_en;
   logic [1:0] bresp, rresp;
   logic [31:0] rdata;
   logic [N*W-1:0] vin_data, vout_src, scal_src;
   logic [31:0] cnt;

   int n_cmp = 0;
   int n_bad = 0;
   logic [31:0] exp_q[$];
   string tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   always_ff @(posedge clk) begin
      if (!rst_n) cnt <= 32'h0000_1000;
      else if (core_en) cnt <= cnt + 32'd1;
   end

   always_comb begin
      for (int k = 0; k < N; k++) begin
         vout_src[k*W +: W] = cnt + 32'(k * 256);
         scal_src[k*W +: W] = cnt + 32'(k);
      end
   end

   vss_vector_regs u0 (
      .clk(clk), .rst_n(rst_n),
      .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
      .s_wdata(wdata), .s_wvalid(wvalid), .s_wready(wready),
      .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
      .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
      .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready),
      .core_en(core_en), .vin_data(vin_data),
      .vout_src(vout_src), .scal_src(scal_src)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
      end
   endtask

   // driver: a write is accepted at the edge after its setup falling edge
   task automatic do_write(input logic [11:0] a, input logic [31:0] d, output logic [31:0] snap);
      @(negedge clk);
      awaddr = a; wdata = d; awvalid = 1'b1; wvalid = 1'b1; snap = cnt;
      @(negedge clk);
      awvalid = 1'b0; wvalid = 1'b0;
      check("R10 bvalid after accept", 32'(bvalid), 32'd1);
      check("R9 bresp okay", 32'(bresp), 32'd0);
      @(negedge clk);
   endtask

   // driver: pushes the expected word; live_k >= 0 means scalar word live_k
   task automatic do_read(input logic [11:0] a, input int live_k, input logic [31:0] fixed, input string tag);
      @(negedge clk);
      araddr = a; arvalid = 1'b1;
      exp_q.push_back(live_k >= 0 ? cnt + 32'(live_k) : fixed);
      tag_q.push_back(tag);
      @(negedge clk);
      arvalid = 1'b0;
      @(negedge clk);
   endtask

   // monitor: read data is due one cycle after acceptance
   always @(negedge clk) begin
      if (rst_n && rvalid) begin
         if (exp_q.size() == 0) begin
            check("R10 unexpected read data", rdata, 32'hxxxx_xxxx);
         end else begin
            check(tag_q.pop_front(), rdata, exp_q.pop_front());
            check("R9 rresp okay", 32'(rresp), 32'd0);
         end
      end
   end

   initial begin : watchdog
      #(CLK_PERIOD * 100000);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : stim
      logic [31:0] snap, cap_snap;
      logic [N*W-1:0] staged;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 core_en", 32'(core_en), 32'd0);
      check("R1 vin_data", 32'(|vin_data), 32'd0);
      do_read(12'h004, -1, 32'd0, "R1 ctrl read");
      do_read(12'h140, -1, 32'd0, "R1 capture read");
      do_read(12'h184, -1, 32'd0, "R1 staging read");

      // R2 enable the source
      do_write(12'h004, 32'd1, snap);
      check("R2 core_en set", 32'(core_en), 32'd1);
      do_read(12'h004, -1, 32'd1, "R2 ctrl readback");

      // R3 staging writes do not reach the core side
      for (int k = 0; k < N; k++) begin
         do_write(12'(32'h180 + 4*k), 32'hA5A0_0000 + 32'(k*17), snap);
         staged[k*W +: W] = 32'hA5A0_0000 + 32'(k*17);
         check("R3 vin_data unchanged", 32'(|vin_data), 32'd0);
      end
      do_read(12'h188, -1, 32'hA5A0_0022, "R3 staging readback");
      do_read(12'h194, -1, 32'hA5A0_0055, "R3 staging readback last");

      // R4 strobe with bit0 clear does nothing, with bit0 set loads all
      do_write(12'h1A0, 32'hFFFF_FFFE, snap);
      check("R4 no load on bit0=0", 32'(|vin_data), 32'd0);
      do_write(12'h1A0, 32'd1, snap);
      for (int k = 0; k < N; k++) check("R4 shadow element", vin_data[k*W +: W], staged[k*W +: W]);
      do_read(12'h1A0, -1, 32'd0, "R8 input strobe reads 0");
      do_write(12'h180, 32'h1234_5678, snap);
      check("R3 vin_data kept after restage", vin_data[31:0], staged[31:0]);

      // R5 capture a coherent snapshot while the source runs
      do_write(12'h160, 32'd1, cap_snap);
      for (int k = 0; k < N; k++)
         do_read(12'(32'h140 + 4*k), -1, cap_snap + 32'(k*256), "R5 captured element");
      repeat (20) @(negedge clk);
      // R6 still the same snapshot
      do_read(12'h140, -1, cap_snap, "R6 capture held first");
      do_read(12'h154, -1, cap_snap + 32'd1280, "R6 capture held last");
      do_read(12'h160, -1, 32'd0, "R8 output strobe reads 0");

      // R7 live scalar reads differ as the counter runs
      for (int k = 0; k < N; k++)
         do_read(12'(32'h10C + 4*k), k, 32'd0, "R7 live scalar");

      // R2 disable: the source stops
      do_write(12'h004, 32'd0, snap);
      check("R2 core_en cleared", 32'(core_en), 32'd0);
      do_write(12'h160, 32'd1, cap_snap);
      do_read(12'h14C, -1, cap_snap + 32'd768, "R5 capture while stopped");
      do_read(12'h120, -1, cap_snap + 32'd5, "R7 scalar while stopped");

      // R9 unmapped accesses
      do_write(12'h200, 32'hDEAD_BEEF, snap);
      do_write(12'h108, 32'hFFFF_FFFF, snap);
      check("R9 core_en untouched", 32'(core_en), 32'd0);
      check("R9 vin_data untouched", vin_data[W +: W], staged[W +: W]);
      do_read(12'h200, -1, 32'd0, "R9 unmapped read");
      do_read(12'h108, -1, 32'd0, "R9 unmapped gap read");

      // R10 write response held while not taken
      bready = 1'b0;
      @(negedge clk);
      awaddr = 12'h004; wdata = 32'd1; awvalid = 1'b1; wvalid = 1'b1;
      @(negedge clk);
      awvalid = 1'b0; wvalid = 1'b0;
      repeat (3) begin
         @(negedge clk);
         check("R10 bvalid held", 32'(bvalid), 32'd1);
      end
      bready = 1'b1;
      @(negedge clk);
      check("R10 bvalid released", 32'(bvalid), 32'd0);
      check("R2 core_en via held write", 32'(core_en), 32'd1);

      repeat (3) @(negedge clk);
      check("R10 read queue drained", 32'(exp_q.size()), 32'd0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule